// File: doc/BRIEF.md
# Snooping Write-Back Invalidate Cache Controller

This block is the coherence engine of one small direct-mapped write-back cache that shares a broadcast bus with other identical caches and a single memory. Every line is either Invalid, Shared (clean, read-only copy) or Exclusive (the only copy, writable and dirty). Processor reads and writes that hit finish locally. Misses, and writes to lines that are only clean copies, become bus transactions. A dirty victim is written back first when a different address needs its line.

The controller also watches every transaction that other caches place on the bus. When another cache asks for a block this cache holds dirty, the controller supplies the block and asserts an abort. The abort cancels the memory reply and also lets memory take the block as a write-back. A foreign write miss removes any local copy. Bus arbitration is external: the controller raises a request and performs its transaction in the single cycle in which it is granted. That transaction is a one-cycle broadcast, and it completes the pending processor request.

Top module: `snoop_wb_cache`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address produces a bus transaction and no request is raised while the processor is idle.
- R2: A processor read of an address not present, on a line that is not dirty, issues one read miss and completes in the grant cycle with the bus data; the line becomes Shared, so repeated reads cause no bus traffic.
- R3: A processor write to an address that is absent or only Shared issues a write miss (a clean write is never a hit), and the line becomes Exclusive with the written value.
- R4: Read hits in Shared or Exclusive and write hits in Exclusive complete with no bus transaction.
- R5: A read that needs a line holding a different address in Exclusive first writes back that block (old address, old data), then issues a read miss; the line ends Shared.
- R6: A write that needs a line holding a different dirty address first writes back that block, then issues a write miss; the line ends Exclusive for the new address.
- R7: A foreign read miss to a block held Exclusive asserts abort with the block data on the supply output, and the line drops to Shared.
- R8: A foreign write miss to a block held in any valid state invalidates the line; if it was Exclusive, abort and supplied data are given as for R7.
- R9: Bus opcodes are 0 idle, 1 read miss, 2 write miss, 3 write-back; a transaction carries the block address and the requester's ID, and takes place in the one cycle in which the grant is high.
- R10: Snooped write-backs and the cache's own transactions never raise abort and never change line state.
- R11: In a cycle when a foreign transaction targets the line index of the pending processor request, that request does not complete; it is re-evaluated against the line's new state afterwards.
- R12: Across any sequence of accesses from both caches, every read returns the value of the most recent write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes at the next rising edge |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus transaction wanted |
| bus_gnt | input | 1 | Bus granted for this cycle |
| mst_op | output | 2 | Opcode of the wanted transaction |
| mst_addr | output | ADDR_W | Block address of the wanted transaction |
| mst_data | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Block data returned on the bus (memory or supplier) |
| snp_op | input | 2 | Opcode currently on the bus |
| snp_addr | input | ADDR_W | Address currently on the bus |
| snp_id | input | ID_W | Requester ID currently on the bus |
| snp_abort | output | 1 | This cache supplies the block and cancels memory |
| snp_data | output | DATA_W | Supplied block data |

## Verification
The assertions rely on the arbiter granting only a cache that requests, granting at most one cache per cycle, and routing the granted cache's opcode, address and ID to every snoop input only in that cycle. They also rely on the processor holding its request stable until ready. The bench arbiter derives grant from the request lines, keeps snoop inputs idle when no grant is given, and drives processor requests from tasks that keep them still until completion. Directed steps cover each state transition. They are followed by a sweep over a handful of conflicting addresses from both caches, checked against a value model, and by one case in which both caches act on the same line in the same cycle.

// File: rtl/snc_pkg.sv
// Shared types for the snooping cache controller: line states and bus opcodes.
package snc_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2
    } lstate_e;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_RDMISS = 2'd1,
        OP_WRMISS = 2'd2,
        OP_WBACK  = 2'd3
    } bus_op_e;
endpackage

// File: rtl/snc_line_array.sv
// Line storage (state, tag, data) for a direct-mapped cache.
// Port A is the full-line update from the processor side; port B changes the
// state only, for snoop actions. Assumes the two ports never hit one line in
// the same cycle (the controller stalls the local request in that case).
module snc_line_array
    import snc_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic [IDX_W-1:0]  a_idx,
    input  lstate_e           a_state,
    input  logic [TAG_W-1:0]  a_tag,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_en,
    input  logic [IDX_W-1:0]  b_idx,
    input  lstate_e           b_state,
    input  logic [IDX_W-1:0]  ra_idx,
    output lstate_e           ra_state,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output lstate_e           rb_state,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data
);
    localparam int LINES = 1 << IDX_W;

    lstate_e           st_all  [LINES];
    logic [TAG_W-1:0]  tag_all [LINES];
    logic [DATA_W-1:0] dat_all [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        lstate_e           st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] dat_q;

        // Per-line register: processor-side update wins, else snoop state change.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= ST_INV;
                tag_q <= '0;
                dat_q <= '0;
            end else if (a_en && a_idx == IDX_W'(g)) begin
                st_q  <= a_state;
                tag_q <= a_tag;
                dat_q <= a_data;
            end else if (b_en && b_idx == IDX_W'(g)) begin
                st_q  <= b_state;
            end
        end

        assign st_all[g]  = st_q;
        assign tag_all[g] = tag_q;
        assign dat_all[g] = dat_q;
    end

    // Read muxes for the processor port and the snoop port.
    always_comb begin
        ra_state = st_all[ra_idx];
        ra_tag   = tag_all[ra_idx];
        ra_data  = dat_all[ra_idx];
        rb_state = st_all[rb_idx];
        rb_tag   = tag_all[rb_idx];
        rb_data  = dat_all[rb_idx];
    end

    // R11: a snoop change and a local update never land on the same line together.
    p_ports_disjoint_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en) |-> (a_idx != b_idx));
endmodule

// File: rtl/snc_snoop.sv
// Snoop responder: decodes the transaction on the bus against the addressed
// line and produces the state change, the abort and the supplied block.
// Assumes snp_op is idle in cycles with no granted transaction.
module snc_snoop
    import snc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    parameter int ID_W   = 1,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    output logic [IDX_W-1:0]  line_idx,
    input  lstate_e           line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_en,
    output lstate_e           upd_state,
    output logic              abort,
    output logic [DATA_W-1:0] sup_data
);
    bus_op_e op;
    logic    foreign;
    logic    match;

    assign op       = bus_op_e'(snp_op);
    assign line_idx = snp_addr[IDX_W-1:0];
    assign foreign  = (snp_id != ID_W'(MY_ID));
    assign match    = foreign && (line_state != ST_INV)
                      && (line_tag == snp_addr[ADDR_W-1:IDX_W]);

    // Snoop decision: downgrade on foreign read miss, invalidate on foreign write miss.
    always_comb begin
        upd_en    = 1'b0;
        upd_state = line_state;
        abort     = 1'b0;
        case (op)
            OP_RDMISS: if (match && line_state == ST_EXC) begin
                upd_en    = 1'b1;
                upd_state = ST_SHR;
                abort     = 1'b1;
            end
            OP_WRMISS: if (match) begin
                upd_en    = 1'b1;
                upd_state = ST_INV;
                abort     = (line_state == ST_EXC);
            end
            default: ;
        endcase
    end

    assign sup_data = abort ? line_data : '0;

    // R10: abort only answers a foreign miss.
    p_abort_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> ((snp_op == 2'd1 || snp_op == 2'd2) && snp_id != ID_W'(MY_ID)));
endmodule

// File: rtl/snc_req_ctrl.sv
// Processor-side controller. Each cycle it derives, from the current state of
// the addressed line, which bus transaction the pending request still needs
// (none, write-back of a dirty victim, read miss or write miss). A miss
// completes the request in its grant cycle; hits complete locally unless a
// foreign snoop targets the same line in that cycle.
// Assumes grant only while bus_req is high and a request held until ready.
module snc_req_ctrl
    import snc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              snoop_conflict,
    output logic [IDX_W-1:0]  line_idx,
    input  lstate_e           line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        mst_op,
    output logic [ADDR_W-1:0] mst_addr,
    output logic [DATA_W-1:0] mst_data,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              upd_en,
    output lstate_e           upd_state,
    output logic [TAG_W-1:0]  upd_tag,
    output logic [DATA_W-1:0] upd_data
);
    logic [TAG_W-1:0] req_tag;
    logic             hit;
    logic             local_done;
    bus_op_e          need_op;

    assign line_idx = cpu_addr[IDX_W-1:0];
    assign req_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign hit      = (line_state != ST_INV) && (line_tag == req_tag);

    // Next bus transaction needed by the pending request.
    always_comb begin
        need_op = OP_IDLE;
        if (cpu_valid) begin
            if (cpu_write) begin
                if (hit && line_state == ST_EXC) need_op = OP_IDLE;
                else if (line_state == ST_EXC)   need_op = OP_WBACK;
                else                             need_op = OP_WRMISS;
            end else begin
                if (hit)                         need_op = OP_IDLE;
                else if (line_state == ST_EXC)   need_op = OP_WBACK;
                else                             need_op = OP_RDMISS;
            end
        end
    end

    assign local_done = cpu_valid && (need_op == OP_IDLE) && !snoop_conflict;

    // Bus master outputs: the victim address for write-back, else the request.
    assign bus_req  = (need_op != OP_IDLE);
    assign mst_op   = need_op;
    assign mst_addr = (need_op == OP_WBACK) ? {line_tag, line_idx} : cpu_addr;
    assign mst_data = line_data;

    // Processor handshake: hits finish locally, misses finish in the grant cycle.
    always_comb begin
        cpu_ready = local_done
                    || (bus_gnt && (need_op == OP_RDMISS || need_op == OP_WRMISS));
        cpu_rdata = (bus_gnt && need_op == OP_RDMISS) ? bus_rdata : line_data;
    end

    // Line update for fills, victim invalidation and write hits.
    always_comb begin
        upd_en    = 1'b0;
        upd_state = line_state;
        upd_tag   = line_tag;
        upd_data  = line_data;
        if (bus_gnt) begin
            case (need_op)
                OP_RDMISS: begin
                    upd_en    = 1'b1;
                    upd_state = ST_SHR;
                    upd_tag   = req_tag;
                    upd_data  = bus_rdata;
                end
                OP_WRMISS: begin
                    upd_en    = 1'b1;
                    upd_state = ST_EXC;
                    upd_tag   = req_tag;
                    upd_data  = cpu_wdata;
                end
                OP_WBACK: begin
                    upd_en    = 1'b1;
                    upd_state = ST_INV;
                end
                default: ;
            endcase
        end else if (local_done && cpu_write) begin
            upd_en    = 1'b1;
            upd_state = ST_EXC;
            upd_tag   = req_tag;
            upd_data  = cpu_wdata;
        end
    end

    // R9: a grant arrives only for a raised request.
    p_gnt_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> bus_req);

    // R4: a request completing without a grant uses no bus.
    p_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !bus_gnt) |-> !bus_req);

    // R5: after a victim write-back the same request moves on to its miss.
    p_wb_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_gnt) && $past(mst_op) == 2'd3 && $past(cpu_valid) && cpu_valid
         && cpu_addr == $past(cpu_addr) && cpu_write == $past(cpu_write))
        |-> (mst_op != 2'd3));
endmodule

// File: rtl/snoop_wb_cache.sv
// Top of the snooping write-back invalidate cache controller: ties the line
// storage, the processor-side controller and the snoop responder together.
// Assumes a single-cycle broadcast bus where the granted cache's opcode,
// address and ID appear on every snoop input during its grant cycle only.
module snoop_wb_cache
    import snc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    parameter int ID_W   = 1,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        mst_op,
    output logic [ADDR_W-1:0] mst_addr,
    output logic [DATA_W-1:0] mst_data,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  ra_idx, rb_idx;
    lstate_e           ra_state, rb_state;
    logic [TAG_W-1:0]  ra_tag, rb_tag;
    logic [DATA_W-1:0] ra_data, rb_data;
    logic              a_en, b_en;
    lstate_e           a_state, b_state;
    logic [TAG_W-1:0]  a_tag;
    logic [DATA_W-1:0] a_data;
    logic              snoop_conflict;

    // Foreign traffic on the requested line index holds off the local request.
    assign snoop_conflict = (snp_op != 2'd0) && (snp_id != ID_W'(MY_ID))
                            && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);

    snc_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_idx(ra_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .b_en(b_en), .b_idx(rb_idx), .b_state(b_state),
        .ra_idx(ra_idx), .ra_state(ra_state), .ra_tag(ra_tag), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_state(rb_state), .rb_tag(rb_tag), .rb_data(rb_data)
    );

    snc_req_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .snoop_conflict(snoop_conflict),
        .line_idx(ra_idx), .line_state(ra_state), .line_tag(ra_tag), .line_data(ra_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mst_op(mst_op), .mst_addr(mst_addr),
        .mst_data(mst_data), .bus_rdata(bus_rdata),
        .upd_en(a_en), .upd_state(a_state), .upd_tag(a_tag), .upd_data(a_data)
    );

    snc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
                .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_op(snp_op), .snp_addr(snp_addr), .snp_id(snp_id),
        .line_idx(rb_idx), .line_state(rb_state), .line_tag(rb_tag), .line_data(rb_data),
        .upd_en(b_en), .upd_state(b_state), .abort(snp_abort), .sup_data(snp_data)
    );

    // R11: no local completion while foreign traffic targets the same line.
    p_snoop_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_conflict |-> !cpu_ready);

    // R1: an idle processor raises no bus request.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> !bus_req);
endmodule

// File: tb/snoop_wb_cache_tb.sv
// Two caches, a fixed-alternation arbiter and a memory model on one bus.
module snoop_wb_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          c_valid [2];
    logic          c_write [2];
    logic [AW-1:0] c_addr  [2];
    logic [DW-1:0] c_wdata [2];

    logic          rdy0, rdy1, req0, req1, ab0, ab1;
    logic [DW-1:0] rd0, rd1, md0, md1, sd0, sd1;
    logic [1:0]    op0, op1;
    logic [AW-1:0] ma0, ma1;
    logic          g0, g1, prio;
    logic [1:0]    b_op;
    logic [AW-1:0] b_addr;
    logic [0:0]    b_id;
    logic          any_ab;
    logic [DW-1:0] b_rdata;
    logic [DW-1:0] mem [256];

    // Arbiter: alternate priority between the two requesters.
    assign g0     = req0 && (!req1 || !prio);
    assign g1     = req1 && !g0;
    assign b_op   = g0 ? op0 : (g1 ? op1 : 2'd0);
    assign b_addr = g0 ? ma0 : (g1 ? ma1 : '0);
    assign b_id   = g1 ? 1'b1 : 1'b0;
    assign any_ab = ab0 | ab1;
    assign b_rdata = ab0 ? sd0 : (ab1 ? sd1 : mem[b_addr]);

    snoop_wb_cache #(.MY_ID(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(c_valid[0]), .cpu_write(c_write[0]),
        .cpu_addr(c_addr[0]), .cpu_wdata(c_wdata[0]), .cpu_ready(rdy0), .cpu_rdata(rd0),
        .bus_req(req0), .bus_gnt(g0), .mst_op(op0), .mst_addr(ma0), .mst_data(md0),
        .bus_rdata(b_rdata), .snp_op(b_op), .snp_addr(b_addr), .snp_id(b_id),
        .snp_abort(ab0), .snp_data(sd0));

    snoop_wb_cache #(.MY_ID(1)) u_peer (
        .clk(clk), .rst_n(rst_n), .cpu_valid(c_valid[1]), .cpu_write(c_write[1]),
        .cpu_addr(c_addr[1]), .cpu_wdata(c_wdata[1]), .cpu_ready(rdy1), .cpu_rdata(rd1),
        .bus_req(req1), .bus_gnt(g1), .mst_op(op1), .mst_addr(ma1), .mst_data(md1),
        .bus_rdata(b_rdata), .snp_op(b_op), .snp_addr(b_addr), .snp_id(b_id),
        .snp_abort(ab1), .snp_data(sd1));

    // Transaction trace recorded by the bus monitor.
    int            tcnt;
    int            r10_viol;
    logic [1:0]    t_op   [64];
    logic [AW-1:0] t_addr [64];
    logic          t_id   [64];
    logic          t_ab   [64];
    logic [DW-1:0] t_data [64];

    // Memory model, priority toggle and bus monitor.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= DW'(i * 3 + 1);
            tcnt     <= 0;
            r10_viol <= 0;
            prio     <= 1'b0;
        end else if (g0 || g1) begin
            prio <= g0;
            if (tcnt < 64) begin
                t_op[tcnt]   <= b_op;
                t_addr[tcnt] <= b_addr;
                t_id[tcnt]   <= b_id[0];
                t_ab[tcnt]   <= any_ab;
                t_data[tcnt] <= g0 ? md0 : md1;
            end
            tcnt <= tcnt + 1;
            if (b_op == 2'd3) mem[b_addr] <= g0 ? md0 : md1;
            else if (any_ab)  mem[b_addr] <= b_rdata;
            if ((b_op == 2'd3 && any_ab) || (g0 && ab0) || (g1 && ab1))
                r10_viol <= r10_viol + 1;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [DW-1:0] refv [256];
    int mark;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic access(input int c, input bit w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd);
        @(negedge clk);
        c_valid[c] = 1'b1; c_write[c] = w; c_addr[c] = a; c_wdata[c] = d;
        #1;
        while (!(c == 0 ? rdy0 : rdy1)) begin
            @(negedge clk);
            #1;
        end
        rd = (c == 0) ? rd0 : rd1;
        if (w) refv[a] = d;
        @(negedge clk);
        c_valid[c] = 1'b0;
    endtask

    task automatic step_begin();
        @(negedge clk);
        mark = tcnt;
    endtask

    task automatic chk_count(input int n, input string tag);
        chk(tcnt - mark == n, {tag, " transaction count"}, tcnt - mark, n);
    endtask

    task automatic chk_tr(input int k, input int op, input int a, input int id,
                          input int ab, input string tag);
        int j;
        j = mark + k;
        chk(t_op[j] == 2'(op), {tag, " R9 opcode"}, int'(t_op[j]), op);
        chk(t_addr[j] == AW'(a), {tag, " R9 address"}, int'(t_addr[j]), a);
        chk(t_id[j] == 1'(id), {tag, " R9 requester"}, int'(t_id[j]), id);
        chk(t_ab[j] == 1'(ab), {tag, " abort"}, int'(t_ab[j]), ab);
    endtask

    localparam logic [AW-1:0] A0 = 8'h01, A1 = 8'h05, A2 = 8'h09, A3 = 8'h0A;

    initial begin
        logic [DW-1:0] r, r1;
        logic [AW-1:0] sw [6];
        for (int c = 0; c < 2; c++) begin
            c_valid[c] = 1'b0; c_write[c] = 1'b0; c_addr[c] = '0; c_wdata[c] = '0;
        end
        for (int i = 0; i < 256; i++) refv[i] = DW'(i * 3 + 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req0 && !req1, "R1 idle no request", int'(req0), 0);

        // R1: cold line goes to the bus.
        step_begin(); access(0, 0, A0, 0, r);
        chk_count(1, "R1"); chk_tr(0, 1, A0, 0, 0, "R1");
        chk(r == 16'd4, "R1 cold read data", r, 4);

        // R3: write miss from Invalid.
        step_begin(); access(0, 1, A1, 16'd10, r);
        chk_count(1, "R3"); chk_tr(0, 2, A1, 0, 0, "R3 write miss");

        // R4: read and write hits in Exclusive.
        step_begin(); access(0, 0, A1, 0, r); access(0, 1, A1, 16'd11, r); access(0, 0, A1, 0, r);
        chk_count(0, "R4"); chk(r == 16'd11, "R4 hit data", r, 11);

        // R7: foreign read of dirty block: supply, abort, memory updated.
        step_begin(); access(1, 0, A1, 0, r);
        chk_count(1, "R7"); chk_tr(0, 1, A1, 1, 1, "R7");
        chk(r == 16'd11, "R7 supplied data", r, 11);
        chk(mem[A1] == 16'd11, "R7 memory takes block", mem[A1], 11);

        // R2: both copies now Shared, reads hit.
        step_begin(); access(0, 0, A1, 0, r); access(1, 0, A1, 0, r1);
        chk_count(0, "R2 shared hits");
        chk(r == 16'd11 && r1 == 16'd11, "R2 shared data", r, 11);

        // R3: write to a Shared line is a miss.
        step_begin(); access(1, 1, A1, 16'd20, r);
        chk_count(1, "R3 shared"); chk_tr(0, 2, A1, 1, 0, "R3 shared write");

        // R6: write to conflicting address evicts dirty block.
        step_begin(); access(1, 1, A2, 16'd40, r);
        chk_count(2, "R6"); chk_tr(0, 3, A1, 1, 0, "R6 writeback"); chk_tr(1, 2, A2, 1, 0, "R6 miss");
        chk(t_data[mark] == 16'd20, "R6 writeback data", t_data[mark], 20);
        chk(mem[A1] == 16'd20, "R6 memory", mem[A1], 20);

        // R8: the earlier foreign write miss invalidated the Shared copy.
        step_begin(); access(0, 0, A1, 0, r);
        chk_count(1, "R8"); chk_tr(0, 1, A1, 0, 0, "R8 reread");
        chk(r == 16'd20, "R8 data", r, 20);

        // R5: read evicting dirty block.
        step_begin(); access(1, 0, A1, 0, r);
        chk_count(2, "R5"); chk_tr(0, 3, A2, 1, 0, "R5 writeback"); chk_tr(1, 1, A1, 1, 0, "R5 miss");
        chk(r == 16'd20, "R5 data", r, 20);
        chk(mem[A2] == 16'd40, "R5 memory", mem[A2], 40);
        step_begin(); access(1, 0, A1, 0, r);
        chk_count(0, "R5 line shared");

        // R8: foreign write miss to an Exclusive block.
        step_begin(); access(0, 1, A3, 16'd50, r); access(1, 1, A3, 16'd60, r);
        chk_count(2, "R8 excl"); chk_tr(1, 2, A3, 1, 1, "R8 excl");
        chk(mem[A3] == 16'd50, "R8 supplied to memory", mem[A3], 50);
        step_begin(); access(0, 0, A3, 0, r);
        chk_tr(0, 1, A3, 0, 1, "R8 invalidated"); chk(r == 16'd60, "R8 data", r, 60);

        // R11: simultaneous local write hit and foreign read miss on one line.
        step_begin(); access(0, 1, A3, 16'd70, r);
        chk_tr(0, 2, A3, 0, 0, "R11 setup");
        step_begin();
        fork
            access(0, 1, A3, 16'd71, r);
            access(1, 0, A3, 0, r1);
        join
        chk_count(2, "R11"); chk_tr(0, 1, A3, 1, 1, "R11 snoop first"); chk_tr(1, 2, A3, 0, 0, "R11 retried as miss");
        chk(r1 == 16'd70, "R11 reader data", r1, 70);
        step_begin(); access(1, 0, A3, 0, r1);
        chk_tr(0, 1, A3, 1, 1, "R11 reread"); chk(r1 == 16'd71, "R11 new data", r1, 71);

        // R12: sweep over conflicting addresses from both caches.
        sw[0] = 8'h01; sw[1] = 8'h05; sw[2] = 8'h09; sw[3] = 8'h0D; sw[4] = 8'h0A; sw[5] = 8'h06;
        for (int i = 0; i < 96; i++) begin
            int c;
            bit w;
            logic [AW-1:0] a;
            logic [DW-1:0] exp;
            c = ((i / 2) % 2) ^ ((i % 3 == 0) ? 1 : 0);
            w = (i % 4 == 1) || (i % 5 == 2);
            a = sw[(i * 7) % 6];
            exp = refv[a];
            access(c, w, a, DW'(16'h100 + i), r);
            if (!w) chk(r == exp, "R12 read value", r, exp);
        end

        // R10: no abort on write-backs or from the requester itself.
        chk(r10_viol == 0, "R10 abort misuse", r10_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule